// File: doc/BRIEF.md
# Multi-Dimensional Element Index Remapper

This block turns a linear element step into a reordered element index. The step counts from 0 up to the vector length minus one. The block treats the step as a position in a walk over a shape of up to three dimensions (x, y, z). The order in which the dimensions are nested is programmable. From the step, the block works out the coordinate on each axis. It then forms the index of that element in storage where x changes fastest. An offset is added, and the sum is reduced modulo a maximum vector length. Because of this reduction, indices may repeat. Repeated indices are legal, and they let the same storage act as an accumulator.

The index is derived only from the step value and the current shape settings. It carries no running count. So a loop that was interrupted can resume at any step and get the same index again. One step is accepted per cycle with a valid strobe, and the result appears one cycle later with its own valid flag.

Top module: `remap_index`

## Requirements
- R1: While rst_ni is low, and after it is released until the first accepted step, idx_vld_o is 0 and idx_o is 0.
- R2: idx_vld_o is high in exactly the cycles that follow a cycle with step_vld_i high, and idx_o then carries the index for the step sampled in that earlier cycle. When step_vld_i is low, idx_o keeps its previous value.
- R3: Each dimension field holds its size minus one. The shape total is Sx*Sy*Sz, where Sx = dim_x_i+1, Sy = dim_y_i+1 and Sz = dim_z_i+1. The step is first reduced modulo this total, so steps at or beyond the total repeat earlier indices.
- R4: With perm_i = 0 (x innermost, then y, then z), the index equals (step mod total + offset) mod MVL, which is the plain sequential order.
- R5: perm_i names the nesting order, innermost axis first: 0 xyz, 1 xzy, 2 yxz, 3 yzx, 4 zxy, 5 zyx. With inner axis a, middle axis b and outer axis c, and s the wrapped step, the coordinates are ca = s mod Sa, cb = (s div Sa) mod Sb and cc = s div (Sa*Sb). The linear index is cx + cy*Sx + cz*Sx*Sy.
- R6: perm_i codes 6 and 7 give the same result as code 0.
- R7: When at least two of the three dimension fields are 0, the index equals (step mod total + offset) mod MVL for every perm_i code.
- R8: offset_i is added to the linear index before the reduction modulo MVL. MVL is taken from mvl_i, and mvl_i = 0 stands for 2^IDX_W. A valid output is always below MVL.
- R9: A 4x4 shape (dim_x_i = dim_y_i = 3) with code 2 and MVL 4 gives an index that holds for four steps and then increases by one (steps 0-3 give 0, steps 4-7 give 1, and so on). A shape with dim_x_i = 3, dim_y_i = 0 and code 0 gives 0,1,2,3 repeated across 16 steps.
- R10: The index depends only on the inputs sampled with the strobe. Any step, issued in any order or reissued after other steps, yields the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dim_x_i | input | DIM_W | Size of x axis minus one |
| dim_y_i | input | DIM_W | Size of y axis minus one |
| dim_z_i | input | DIM_W | Size of z axis minus one |
| perm_i | input | 3 | Nesting order code |
| offset_i | input | IDX_W | Offset added to the linear index |
| mvl_i | input | IDX_W | Modulus for the result (0 means 2^IDX_W) |
| step_i | input | IDX_W | Linear element step |
| step_vld_i | input | 1 | Step strobe |
| idx_o | output | IDX_W | Remapped element index |
| idx_vld_o | output | 1 | Index valid, one cycle after the strobe |

## Verification
A sequential 4x4 walk that runs past the shape total separates correct wrapping from a missing step reduction. An asymmetric 3x2x4 shape, swept under all eight codes, gives each ordering its own index sequence, so any swapped axis or misdecoded code shows up. Degenerate single-axis shapes with an offset confirm that the order has no effect there. Large offsets with the default and small moduli exercise the final reduction. Gapped strobes test the hold behaviour, and pseudo-random parameters with reissued steps show that nothing depends on history.

// File: rtl/remap_index_pkg.sv
`timescale 1ns/1ps
package remap_index_pkg;

  typedef enum logic [1:0] {
    AX_X = 2'd0,
    AX_Y = 2'd1,
    AX_Z = 2'd2
  } axis_e;

  typedef struct packed {
    axis_e inner;
    axis_e mid;
    axis_e outer;
  } nest_t;

  // innermost axis first; unused codes fall back to xyz
  function automatic nest_t decode_nest(input logic [2:0] code);
    nest_t n;
    case (code)
      3'd1:    n = '{inner: AX_X, mid: AX_Z, outer: AX_Y};
      3'd2:    n = '{inner: AX_Y, mid: AX_X, outer: AX_Z};
      3'd3:    n = '{inner: AX_Y, mid: AX_Z, outer: AX_X};
      3'd4:    n = '{inner: AX_Z, mid: AX_X, outer: AX_Y};
      3'd5:    n = '{inner: AX_Z, mid: AX_Y, outer: AX_X};
      default: n = '{inner: AX_X, mid: AX_Y, outer: AX_Z};
    endcase
    return n;
  endfunction

endpackage

// File: rtl/remap_index_divmod.sv
`timescale 1ns/1ps
// Unrolled restoring divider; den_i must be nonzero.
module remap_index_divmod #(
  parameter int NUM_W = 8,
  parameter int DEN_W = 4
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o
);

  logic [DEN_W-1:0] part [NUM_W+1];

  assign part[NUM_W] = '0;

  for (genvar k = NUM_W - 1; k >= 0; k--) begin : g_stage
    logic [DEN_W:0]   trial;
    logic [DEN_W-1:0] diff;
    assign trial    = {part[k+1], num_i[k]};
    assign diff     = trial[DEN_W-1:0] - den_i;
    assign quo_o[k] = (trial >= {1'b0, den_i});
    assign part[k]  = quo_o[k] ? diff : trial[DEN_W-1:0];
  end

  assign rem_o = part[0];

endmodule

// File: rtl/remap_index_shape.sv
`timescale 1ns/1ps
module remap_index_shape
  import remap_index_pkg::*;
#(
  parameter int DIM_W = 3,
  parameter int IDX_W = 8
) (
  input  logic [DIM_W-1:0]     dim_x_i,
  input  logic [DIM_W-1:0]     dim_y_i,
  input  logic [DIM_W-1:0]     dim_z_i,
  input  logic [2:0]           perm_i,
  input  logic [IDX_W-1:0]     step_i,
  output logic [3*DIM_W:0]     lin_o,
  output logic [3*DIM_W:0]     total_o
);

  localparam int SZ_W  = DIM_W + 1;
  localparam int TOT_W = 3 * DIM_W + 1;

  logic [SZ_W-1:0]  size_x, size_y, size_z;
  logic [SZ_W-1:0]  sz_in, sz_mid;
  logic [TOT_W-1:0] s_wrap, q_in, c_out;
  logic [SZ_W-1:0]  c_in, c_mid;
  logic [IDX_W-1:0] wrap_quo_unused;
  logic [TOT_W-1:0] coord [3];
  nest_t            nest;

  assign size_x = {1'b0, dim_x_i} + SZ_W'(1);
  assign size_y = {1'b0, dim_y_i} + SZ_W'(1);
  assign size_z = {1'b0, dim_z_i} + SZ_W'(1);
  assign nest   = decode_nest(perm_i);

  assign total_o = TOT_W'(size_x) * TOT_W'(size_y) * TOT_W'(size_z);

  always_comb begin
    case (nest.inner)
      AX_Y:    sz_in = size_y;
      AX_Z:    sz_in = size_z;
      default: sz_in = size_x;
    endcase
    case (nest.mid)
      AX_X:    sz_mid = size_x;
      AX_Z:    sz_mid = size_z;
      default: sz_mid = size_y;
    endcase
  end

  // step modulo shape total
  remap_index_divmod #(.NUM_W(IDX_W), .DEN_W(TOT_W)) u_wrap (
    .num_i (step_i),
    .den_i (total_o),
    .quo_o (wrap_quo_unused),
    .rem_o (s_wrap)
  );

  remap_index_divmod #(.NUM_W(TOT_W), .DEN_W(SZ_W)) u_inner (
    .num_i (s_wrap),
    .den_i (sz_in),
    .quo_o (q_in),
    .rem_o (c_in)
  );

  // quotient of the middle stage is the outer coordinate (below its size)
  remap_index_divmod #(.NUM_W(TOT_W), .DEN_W(SZ_W)) u_mid (
    .num_i (q_in),
    .den_i (sz_mid),
    .quo_o (c_out),
    .rem_o (c_mid)
  );

  always_comb begin
    for (int a = 0; a < 3; a++) begin
      if (nest.inner == axis_e'(a))    coord[a] = TOT_W'(c_in);
      else if (nest.mid == axis_e'(a)) coord[a] = TOT_W'(c_mid);
      else                             coord[a] = c_out;
    end
  end

  assign lin_o = coord[0]
               + coord[1] * TOT_W'(size_x)
               + coord[2] * TOT_W'(size_x) * TOT_W'(size_y);

endmodule

// File: rtl/remap_index.sv
`timescale 1ns/1ps
module remap_index #(
  parameter int DIM_W = 3,
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIM_W-1:0] dim_x_i,
  input  logic [DIM_W-1:0] dim_y_i,
  input  logic [DIM_W-1:0] dim_z_i,
  input  logic [2:0]       perm_i,
  input  logic [IDX_W-1:0] offset_i,
  input  logic [IDX_W-1:0] mvl_i,
  input  logic [IDX_W-1:0] step_i,
  input  logic             step_vld_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             idx_vld_o
);

  localparam int TOT_W = 3 * DIM_W + 1;
  localparam int SUM_W = ((TOT_W > IDX_W) ? TOT_W : IDX_W) + 1;
  localparam int MOD_W = IDX_W + 1;

  logic [TOT_W-1:0] lin, total;
  logic [SUM_W-1:0] sum;
  logic [MOD_W-1:0] mvl_eff, red;
  logic [SUM_W-1:0] mvl_quo_unused;
  logic             red_msb_unused;

  remap_index_shape #(.DIM_W(DIM_W), .IDX_W(IDX_W)) u_shape (
    .dim_x_i (dim_x_i),
    .dim_y_i (dim_y_i),
    .dim_z_i (dim_z_i),
    .perm_i  (perm_i),
    .step_i  (step_i),
    .lin_o   (lin),
    .total_o (total)
  );

  assign sum     = SUM_W'(lin) + SUM_W'(offset_i);
  assign mvl_eff = (mvl_i == '0) ? (MOD_W'(1) << IDX_W) : {1'b0, mvl_i};

  remap_index_divmod #(.NUM_W(SUM_W), .DEN_W(MOD_W)) u_mvl (
    .num_i (sum),
    .den_i (mvl_eff),
    .quo_o (mvl_quo_unused),
    .rem_o (red)
  );

  assign red_msb_unused = red[IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o     <= '0;
      idx_vld_o <= 1'b0;
    end else begin
      idx_vld_o <= step_vld_i;
      if (step_vld_i) idx_o <= red[IDX_W-1:0];
    end
  end

  assert_vld_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_vld_i |=> idx_vld_o);

  assert_vld_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_vld_i |=> !idx_vld_o);

  assert_idx_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_vld_i |=> $stable(idx_o));

  assert_below_mvl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_vld_o |-> ({1'b0, idx_o} < $past(mvl_eff)));

  assert_in_shape_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_vld_i |-> (lin < total));

endmodule

// File: tb/remap_index_bench.sv
`timescale 1ns/1ps
module remap_index_bench;

  localparam int DIM_W = 3;
  localparam int IDX_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIM_W-1:0] dx = '0, dy = '0, dz = '0;
  logic [2:0]       perm = '0;
  logic [IDX_W-1:0] off = '0, mvl = '0, step = '0;
  logic             vld = 1'b0;
  logic [IDX_W-1:0] idx_o;
  logic             idx_vld_o;

  always #2.5 clk = ~clk;

  remap_index #(.DIM_W(DIM_W), .IDX_W(IDX_W)) u_remap_index (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dim_x_i    (dx),
    .dim_y_i    (dy),
    .dim_z_i    (dz),
    .perm_i     (perm),
    .offset_i   (off),
    .mvl_i      (mvl),
    .step_i     (step),
    .step_vld_i (vld),
    .idx_o      (idx_o),
    .idx_vld_o  (idx_vld_o)
  );

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    cmp_en = 0, done = 0;
  int    exp_idx = 0;
  bit    exp_vld = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int ref_idx(int x, int y, int z, int p, int o, int m, int s);
    int sz[3], c[3], ord[3];
    int tot, r, lin, mm;
    sz[0] = x + 1; sz[1] = y + 1; sz[2] = z + 1;
    tot = sz[0] * sz[1] * sz[2];
    r = s % tot;
    case (p)
      1: begin ord[0] = 0; ord[1] = 2; ord[2] = 1; end
      2: begin ord[0] = 1; ord[1] = 0; ord[2] = 2; end
      3: begin ord[0] = 1; ord[1] = 2; ord[2] = 0; end
      4: begin ord[0] = 2; ord[1] = 0; ord[2] = 1; end
      5: begin ord[0] = 2; ord[1] = 1; ord[2] = 0; end
      default: begin ord[0] = 0; ord[1] = 1; ord[2] = 2; end
    endcase
    c[ord[0]] = r % sz[ord[0]];
    c[ord[1]] = (r / sz[ord[0]]) % sz[ord[1]];
    c[ord[2]] = r / (sz[ord[0]] * sz[ord[1]]);
    lin = c[0] + c[1] * sz[0] + c[2] * sz[0] * sz[1];
    mm = (m == 0) ? 256 : m;
    return (lin + o) % mm;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_idx = 0;
      exp_vld = 0;
    end else begin
      exp_vld = vld;
      if (vld) exp_idx = ref_idx(int'(dx), int'(dy), int'(dz), int'(perm),
                                 int'(off), int'(mvl), int'(step));
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      n_chk++;
      if (idx_vld_o !== exp_vld || idx_o !== exp_idx[IDX_W-1:0]) begin
        n_bad++;
        $display("FAIL %s: vld=%0b idx=%0d expected vld=%0b idx=%0d",
                 cur_req, idx_vld_o, idx_o, exp_vld, exp_idx);
      end
    end
  end

  task automatic drive(int x, int y, int z, int p, int o, int m, int s, bit v);
    @(negedge clk);
    dx = x[DIM_W-1:0]; dy = y[DIM_W-1:0]; dz = z[DIM_W-1:0];
    perm = p[2:0]; off = o[IDX_W-1:0]; mvl = m[IDX_W-1:0];
    step = s[IDX_W-1:0]; vld = v;
  endtask

  // explicit check just after the edge that captured the last drive
  task automatic spot(int expv, string req);
    @(posedge clk);
    #1;
    n_chk++;
    if (idx_o !== expv[IDX_W-1:0]) begin
      n_bad++;
      $display("FAIL %s: idx=%0d expected %0d", req, idx_o, expv);
    end
  endtask

  function automatic int nxt(int lim);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % lim);
  endfunction

  initial begin
    #(5 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(posedge clk);
    #1 cmp_en = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 sequential order, R3 wrap past total 16
    for (int s = 0; s < 40; s++) begin
      cur_req = (s >= 16) ? "R3" : "R4";
      drive(3, 3, 0, 0, 0, 0, s, 1);
    end

    // R9 4x4 y-innermost with MVL 4, then 4x1 cycling
    cur_req = "R9";
    for (int s = 0; s < 16; s++) begin
      drive(3, 3, 0, 2, 0, 4, s, 1);
      spot(s / 4, "R9");
    end
    for (int s = 0; s < 16; s++) begin
      drive(3, 0, 0, 0, 0, 0, s, 1);
      spot(s % 4, "R9");
    end

    // R5 all orderings on 3x2x4, R6 codes 6 and 7
    for (int p = 0; p < 8; p++) begin
      cur_req = (p > 5) ? "R6" : "R5";
      for (int s = 0; s < 30; s++) drive(2, 1, 3, p, 0, 0, s, 1);
    end
    drive(2, 1, 3, 3, 0, 0, 1, 1); spot(3, "R5");
    drive(2, 1, 3, 5, 0, 0, 1, 1); spot(6, "R5");
    drive(2, 1, 3, 6, 0, 0, 7, 1); spot(7, "R6");
    drive(2, 1, 3, 7, 0, 0, 25, 1); spot(1, "R6");

    // R7 single nonunit axis: order has no effect
    cur_req = "R7";
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 12; s++) begin
        drive(0, 4, 0, p, 5, 0, s, 1);
        spot((s % 5) + 5, "R7");
      end

    // R8 offset then modulo
    cur_req = "R8";
    for (int s = 0; s < 10; s++) begin
      drive(3, 3, 3, 0, 200, 0, s * 9, 1);
      spot(((s * 9) % 64 + 200) % 256, "R8");
    end
    for (int s = 0; s < 12; s++) drive(1, 2, 1, 4, 7, 10, s, 1);

    // R2 gapped strobes and hold
    cur_req = "R2";
    for (int i = 0; i < 24; i++) drive(2, 2, 0, 1, 3, 0, i, (i % 3) != 0);
    repeat (3) drive(2, 2, 0, 1, 3, 0, 0, 0);

    // R10 pseudo-random parameters, arbitrary step order, reissue
    cur_req = "R10";
    for (int i = 0; i < 200; i++)
      drive(nxt(8), nxt(8), nxt(8), nxt(8), nxt(256), nxt(256), nxt(256), nxt(5) != 0);
    drive(2, 3, 1, 4, 11, 0, 37, 1);
    spot(ref_idx(2, 3, 1, 4, 11, 0, 37), "R10");
    for (int s = 60; s > 40; s--) drive(2, 3, 1, 4, 11, 0, s, 1);
    drive(2, 3, 1, 4, 11, 0, 37, 1);
    spot(ref_idx(2, 3, 1, 4, 11, 0, 37), "R10");

    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule